// File: doc/BRIEF.md
# Pixel Clip and Output Bus Formatter

This block sits directly after the column transform stage of a two-dimensional transform engine and drives the engine's 12-bit output bus. It receives a wide signed fixed-point result, rounds it to an integer, and clips it to the range of the selected output format. A mode input selects between the two directions of the transform. In the forward direction the bus carries a full 12-bit two's complement coefficient. In the inverse direction the bus carries an 8-bit or 9-bit two's complement pixel.

Pixels are packed from the top of the bus. The unused low bits are driven to zero, so downstream logic can read either pixel width at the same bit weight. A block-start marker travels alongside the data with the same single register of delay. An output enable, applied after the register, releases the bus to high impedance.

Top module: `pixel_clip_fmt`

## Requirements
- R1: With `inv_mode`=0, `dout[11:0]` carries the rounded input as a 12-bit two's complement coefficient on all twelve bits. `pix9` has no effect in this mode.
- R2: With `inv_mode`=0, a rounded value above 2047 yields 2047 (0x7FF), and a rounded value below -2048 yields -2048 (0x800).
- R3: With `inv_mode`=1 and `pix9`=0, the rounded value is clipped to -128..127. The clipped value is placed on bits 11..4, and bits 3..0 are 0.
- R4: With `inv_mode`=1 and `pix9`=1, the rounded value is clipped to -256..255. The clipped value is placed on bits 11..3, and bits 2..0 are 0.
- R5: `din` is signed fixed point with 4 fractional bits. It is rounded to the nearest integer before clipping, and exact halves round away from zero (2.5 gives 3, -2.5 gives -3).
- R6: Data has one clock of latency. `dout` shows the result of the inputs sampled at the previous rising edge, and a change on `din` between edges does not alter `dout`.
- R7: `blk_out` equals `blk_start` as sampled at the previous rising edge.
- R8: When `oe`=0, `dout` is released (high impedance). `oe` acts after the register, without delay, and does not disturb the registered data: the data is visible again as soon as `oe` returns to 1.
- R9: While `rst_n` is low at a rising edge, the registered data is cleared to 0 and `blk_out` is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 20 | Signed fixed-point result from the column stage, 4 fractional bits |
| inv_mode | input | 1 | 0 = forward (coefficient out), 1 = inverse (pixel out) |
| pix9 | input | 1 | Pixel width in inverse mode: 0 = 8-bit, 1 = 9-bit |
| blk_start | input | 1 | First sample of a block |
| oe | input | 1 | Output enable for `dout` |
| dout | output | 12 | Formatted output bus |
| blk_out | output | 1 | Block-start marker aligned with `dout` |

## Verification
Each data result and each block marker is due exactly one rising edge after the inputs that produce it. The output enable takes effect in the same cycle, with no edge between. The bench drives every input on a falling edge and compares the outputs on the next falling edge, one edge later, against a reference computed by a bench function. It checks the enable in the cycle it is changed. One check samples just after a mid-cycle input change and before the next edge, to show that the output still holds the earlier result.

// File: rtl/pclip_pkg.sv
// Package: shared constants for the pixel clip and bus formatter.
// Lane indices name the three output formats. Lane widths are derived
// from the bus width and the two pixel widths.
package pclip_pkg;

    localparam int BUS_W      = 12;
    localparam int PIX_NAR_W  = 8;
    localparam int PIX_WIDE_W = 9;

    localparam int N_LANES    = 3;
    localparam int LANE_COEF  = 0;
    localparam int LANE_WIDE  = 1;
    localparam int LANE_NAR   = 2;

    // Width of the value carried by a given lane.
    function automatic int lane_width(input int idx);
        case (idx)
            LANE_COEF: return BUS_W;
            LANE_WIDE: return PIX_WIDE_W;
            default:   return PIX_NAR_W;
        endcase
    endfunction

endpackage

// File: rtl/pclip_round.sv
// Module: pclip_round
// Rounds a signed fixed-point value to the nearest integer. Exact halves
// go away from zero.
// Assumes: FRAC_W >= 0. The result is one bit wider than the integer part,
// so the rounding increment can never wrap.
module pclip_round #(
    parameter int IN_W   = 20,
    parameter int FRAC_W = 4,
    parameter int OUT_W  = IN_W - FRAC_W + 1
) (
    input  logic signed [IN_W-1:0]  val_i,
    output logic signed [OUT_W-1:0] val_o
);

    generate
        if (FRAC_W == 0) begin : g_int
            // Purpose: no fraction, so only sign-extend.
            assign val_o = {val_i[IN_W-1], val_i};
        end else begin : g_frac
            localparam int HALF = 1 << (FRAC_W - 1);
            logic signed [IN_W:0] ext;
            logic signed [IN_W:0] bias;
            logic signed [IN_W:0] sum;

            // Purpose: add half (one less for negatives), then floor by
            // dropping the fraction bits.
            always_comb begin
                ext   = {val_i[IN_W-1], val_i};
                bias  = val_i[IN_W-1] ? (IN_W+1)'(HALF - 1) : (IN_W+1)'(HALF);
                sum   = ext + bias;
                val_o = sum[IN_W:FRAC_W];
            end
        end
    endgenerate

endmodule

// File: rtl/pclip_lane.sv
// Module: pclip_lane
// Saturates a signed integer to PIX_W bits and left-aligns it on a
// BUS_W-wide bus. The bus bits below the value are forced to zero.
// Assumes: IN_W > PIX_W and BUS_W >= PIX_W.
module pclip_lane #(
    parameter int IN_W  = 17,
    parameter int PIX_W = 8,
    parameter int BUS_W = 12
) (
    input  logic signed [IN_W-1:0] val_i,
    output logic [BUS_W-1:0]       bus_o
);

    localparam int PAD_W = BUS_W - PIX_W;
    localparam int EXT_W = IN_W - PIX_W + 1;

    localparam logic signed [IN_W-1:0] MAXV =
        $signed({{EXT_W{1'b0}}, {(PIX_W-1){1'b1}}});
    localparam logic signed [IN_W-1:0] MINV =
        $signed({{EXT_W{1'b1}}, {(PIX_W-1){1'b0}}});

    logic [PIX_W-1:0] pix;

    // Purpose: clamp to the representable PIX_W-bit range.
    always_comb begin
        if (val_i > MAXV) begin
            pix = MAXV[PIX_W-1:0];
        end else if (val_i < MINV) begin
            pix = MINV[PIX_W-1:0];
        end else begin
            pix = val_i[PIX_W-1:0];
        end
    end

    generate
        if (PAD_W == 0) begin : g_full
            // Purpose: the value fills the bus.
            assign bus_o = pix;
        end else begin : g_pad
            // Purpose: MSB-align and zero the unused low bits.
            assign bus_o = {pix, {PAD_W{1'b0}}};
        end
    endgenerate

endmodule

// File: rtl/pixel_clip_fmt.sv
// Module: pixel_clip_fmt (top)
// Rounds the column stage result, clips it to the selected format (12-bit
// coefficient, 9-bit or 8-bit pixel), packs it MSB-first on the bus and
// registers it. The block marker takes the same single register stage.
// The output enable acts after the register.
// Assumes: din carries FRAC_W fractional bits, and inv_mode and pix9 are
// steady for the sample they accompany.
module pixel_clip_fmt
    import pclip_pkg::*;
#(
    parameter int IN_W   = 20,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_W-1:0]   din,
    input  logic              inv_mode,
    input  logic              pix9,
    input  logic              blk_start,
    input  logic              oe,
    output logic [BUS_W-1:0]  dout,
    output logic              blk_out
);

    localparam int RND_W = IN_W - FRAC_W + 1;

    logic signed [RND_W-1:0] rnd_val;
    logic [BUS_W-1:0]        lane_bus [N_LANES];
    logic [BUS_W-1:0]        sel_bus;
    logic [BUS_W-1:0]        q_data;
    logic                    q_blk;

    pclip_round #(
        .IN_W   (IN_W),
        .FRAC_W (FRAC_W),
        .OUT_W  (RND_W)
    ) u_round (
        .val_i (signed'(din)),
        .val_o (rnd_val)
    );

    generate
        for (genvar g = 0; g < N_LANES; g++) begin : g_lane
            pclip_lane #(
                .IN_W  (RND_W),
                .PIX_W (lane_width(g)),
                .BUS_W (BUS_W)
            ) u_lane (
                .val_i (rnd_val),
                .bus_o (lane_bus[g])
            );
        end
    endgenerate

    // Purpose: choose the lane for the transform direction and pixel width.
    always_comb begin
        if (!inv_mode) begin
            sel_bus = lane_bus[LANE_COEF];
        end else if (pix9) begin
            sel_bus = lane_bus[LANE_WIDE];
        end else begin
            sel_bus = lane_bus[LANE_NAR];
        end
    end

    // Purpose: output register for data and block marker, with sync reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_data <= '0;
            q_blk  <= 1'b0;
        end else begin
            q_data <= sel_bus;
            q_blk  <= blk_start;
        end
    end

    // Purpose: release the bus when the enable is low.
    assign dout    = oe ? q_data : 'z;
    assign blk_out = q_blk;

    AST_BLK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (q_blk == $past(blk_start)));                 // R7

    AST_FWD_CLIP_HI: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!inv_mode) && $past(rnd_val > 2047))
        |-> (q_data == 12'h7FF));                                      // R2

    AST_FWD_CLIP_LO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!inv_mode) && $past(rnd_val < -2048))
        |-> (q_data == 12'h800));                                      // R2

    AST_NAR_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(inv_mode && !pix9))
        |-> (q_data[3:0] == 4'h0));                                    // R3

    AST_WIDE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(inv_mode && pix9))
        |-> (q_data[2:0] == 3'h0));                                    // R4

endmodule

// File: tb/tb_pixel_clip_fmt.sv
module tb_pixel_clip_fmt;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [19:0] din;
    logic        inv_mode, pix9, blk_start, oe;
    logic [11:0] dout;
    logic        blk_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pixel_clip_fmt dut (
        .clk (clk), .rst_n (rst_n), .din (din), .inv_mode (inv_mode),
        .pix9 (pix9), .blk_start (blk_start), .oe (oe),
        .dout (dout), .blk_out (blk_out)
    );

    // Reference: round half away from zero, clip, MSB-align.
    function automatic logic [11:0] model(input logic [19:0] raw,
                                          input bit inv, input bit p9);
        longint v, a, r, hi, lo, mask;
        int w;
        v = longint'($signed(raw));
        a = (v < 0) ? -v : v;
        r = (a + 8) >> 4;
        if (v < 0) r = -r;
        w = !inv ? 12 : (p9 ? 9 : 8);
        hi = (longint'(1) <<< (w - 1)) - 1;
        lo = -(longint'(1) <<< (w - 1));
        if (r > hi) r = hi;
        if (r < lo) r = lo;
        mask = (longint'(1) <<< w) - 1;
        return 12'((r & mask) << (12 - w));
    endfunction

    task automatic chk(input string req, input logic [11:0] act,
                       input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, move to the next falling edge.
    task automatic apply(input logic [19:0] raw, input bit inv, input bit p9,
                         input bit blk);
        din = raw; inv_mode = inv; pix9 = p9; blk_start = blk;
        @(negedge clk);
    endtask

    task automatic vec(input string req, input logic [19:0] raw,
                       input bit inv, input bit p9);
        apply(raw, inv, p9, 1'b0);
        chk(req, dout, model(raw, inv, p9));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; oe = 1'b1;
        din = 20'h01234; inv_mode = 1'b0; pix9 = 1'b0; blk_start = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R9 data", dout, 12'h000);
        chk("R9 blk", {11'b0, blk_out}, 12'h000);
        rst_n = 1'b1;

        vec("R1 fwd 100", 20'd1600, 1'b0, 1'b0);
        chk("R1 fwd 100 exact", dout, 12'd100);
        vec("R1 pix9 ignored in fwd", 20'd4800, 1'b0, 1'b1);
        chk("R1 fwd 300", dout, 12'd300);
        vec("R2 fwd 2047.5 clip", 20'd32760, 1'b0, 1'b0);
        chk("R2 high", dout, 12'h7FF);
        vec("R2 fwd -2048.5 clip", -20'sd32776, 1'b0, 1'b0);
        chk("R2 low", dout, 12'h800);
        vec("R2 most negative", 20'h80000, 1'b0, 1'b0);
        chk("R2 min", dout, 12'h800);
        vec("R5 +2.5", 20'd40, 1'b0, 1'b0);
        chk("R5 tie up", dout, 12'h003);
        vec("R5 -2.5", -20'sd40, 1'b0, 1'b0);
        chk("R5 tie down", dout, 12'hFFD);
        vec("R5 2.4375", 20'd39, 1'b0, 1'b0);
        chk("R5 below half", dout, 12'h002);
        vec("R3 127.5", 20'd2040, 1'b1, 1'b0);
        chk("R3 high", dout, 12'h7F0);
        vec("R3 -200", -20'sd3200, 1'b1, 1'b0);
        chk("R3 low", dout, 12'h800);
        vec("R3 -5", -20'sd80, 1'b1, 1'b0);
        chk("R3 in range", dout, 12'hFB0);
        vec("R4 255", 20'd4080, 1'b1, 1'b1);
        chk("R4 high", dout, 12'h7F8);
        vec("R4 -256.6", -20'sd4106, 1'b1, 1'b1);
        chk("R4 low", dout, 12'h800);
        vec("R4 200", 20'd3200, 1'b1, 1'b1);
        chk("R4 in range", dout, 12'h640);

        // R6: mid-cycle input change leaves the output on the prior result
        apply(20'd1600, 1'b0, 1'b0, 1'b0);
        din = 20'd3200;
        #2;
        chk("R6 hold before edge", dout, 12'd100);
        @(negedge clk);
        chk("R6 after edge", dout, 12'd200);

        // R7: block marker pulse
        apply(20'd16, 1'b0, 1'b0, 1'b1);
        chk("R7 marker high", {11'b0, blk_out}, 12'h001);
        apply(20'd16, 1'b0, 1'b0, 1'b0);
        chk("R7 marker low", {11'b0, blk_out}, 12'h000);

        // R8: enable low releases bus; data returns when high again
        apply(20'd1600, 1'b0, 1'b0, 1'b0);
        oe = 1'b0;
        #1;
        checks++;
        if (!((dout === 12'bz) || (dout === 12'h000))) begin
            fails++;
            $display("FAIL R8 released actual=%h expected=zzz", dout);
        end
        oe = 1'b1;
        #1;
        chk("R8 data back", dout, 12'd100);
        @(negedge clk);

        // Random mix of modes, widths, magnitudes and markers
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            logic [31:0] t;
            logic [19:0] raw;
            r = $urandom;
            t = $urandom;
            raw = (r[4:3] == 2'b00) ? t[19:0] : {{6{t[13]}}, t[13:0]};
            apply(raw, r[0], r[1], r[2]);
            chk(r[0] ? (r[1] ? "R4 rand" : "R3 rand") : "R1 rand",
                dout, model(raw, r[0], r[1]));
            chk("R7 rand", {11'b0, blk_out}, {11'b0, r[2]});
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule